// File: doc/BRIEF.md
# Wide-Word Microcode Sequencer

This block is the control store and address sequencer of a microcoded CPU control unit. Each clock it reads one 72-bit microinstruction from a synchronous ROM. It hands the decoded control fields to the datapath: the two ALU operand selects, the ALU opcode, a 16-bit inline constant with its steering code, and eight load strobes.

In the same cycle it works out the address of the next microinstruction. That address comes from the plain successor field, a branch target chosen by a tested condition flag, or a single link register that holds a return point. The link register lets microcode call a shared subroutine and come back without a stack.

An external dispatch strobe from the instruction decoder overrides the address choice for one cycle, so control enters the microroutine of a newly decoded instruction. The ROM image is computed by a package function. The datapath, ALU and decoder sit outside the block.

Top module: `ucode_seq`

## Requirements
- R1: While `rst` is high, the fetch address is forced to 0. At the first sampling after reset, `upc_o` reads 0 and the field outputs show microword 0.
- R2: With sequencing code 0, or any code from 3 to 7, the next microaddress is the word's successor field. This applies when dispatch is low.
- R3: With a sequencing code from 8 to 15, condition flag number code[1:0] is tested. Bit 2 of the code inverts the test. If the test is true, the branch-target field is taken; otherwise the successor field is taken.
- R4: Sequencing code 2 always takes the branch-target field.
- R5: Sequencing code 1 jumps to the address held in the link register.
- R6: When strobe bit 7 (link) of the current word is set, the link register loads that word's return field at the end of the cycle. Only one level is kept: a later link load replaces the earlier value.
- R7: When `disp_vld_i` is high, the next microaddress is `disp_addr_i`, whatever the current word's sequencing code.
- R8: The field outputs always belong to the word at `upc_o` in the same cycle. The constant, operand selects, opcode, steering code and strobes are all aligned. Strobe bits: 0 pc, 1 write data, 2 temp1, 3 temp2, 4 effective address, 5 status, 6 instruction, 7 link.
- R9: Microword layout, from the LSB: successor [7:0], branch target [15:8], return [23:16], sequencing [27:24], operand A select [30:28], operand B select [35:31], opcode [39:36], constant [55:40], steering [57:56], strobes [65:58], zero padding [71:66].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_vld_i | input | 1 | Dispatch strobe from instruction decode |
| disp_addr_i | input | 8 | Microroutine entry address |
| flags_i | input | 4 | Datapath condition flags |
| upc_o | output | 8 | Current microaddress |
| asel_o | output | 3 | ALU operand A select |
| bsel_o | output | 5 | ALU operand B select |
| aluop_o | output | 4 | ALU operation |
| konst_o | output | 16 | Inline constant |
| kdst_o | output | 2 | Constant steering (1 = A, 2 = B) |
| ld_o | output | 8 | Register load strobes |

## Verification
A small microprogram is walked through the sequence successor, call, subroutine, return, then taken and untaken branches on both flag polarities. This separates a wrong choice between the successor and the branch target, as well as an inverted test. Irrelevant flag bits are set high during the branch tests, which exposes a wrong flag index. A second call with a different return point shows whether the link register really gets overwritten. Dispatch is applied on top of a return word, which shows that dispatch wins over the link.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UA_W   = 8;
  localparam int UW_W   = 72;
  localparam int K_W    = 16;
  localparam int ASEL_W = 3;
  localparam int BSEL_W = 5;
  localparam int OP_W   = 4;
  localparam int SEQ_W  = 4;
  localparam int LD_W   = 8;
  localparam int KD_W   = 2;
  localparam int FLAG_W = 4;
  localparam int FSEL_W = $clog2(FLAG_W);
  localparam int PAD_W  = UW_W - (3*UA_W + SEQ_W + ASEL_W + BSEL_W + OP_W + K_W + KD_W + LD_W);
  localparam int DEPTH  = 1 << UA_W;

  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic [LD_W-1:0]   ld;
    logic [KD_W-1:0]   kdst;
    logic [K_W-1:0]    konst;
    logic [OP_W-1:0]   op;
    logic [BSEL_W-1:0] bsel;
    logic [ASEL_W-1:0] asel;
    logic [SEQ_W-1:0]  seq;
    logic [UA_W-1:0]   ret;
    logic [UA_W-1:0]   alt;
    logic [UA_W-1:0]   nxt;
  } uword_t;

  localparam logic [SEQ_W-1:0] SQ_NEXT = 4'd0;
  localparam logic [SEQ_W-1:0] SQ_RET  = 4'd1;
  localparam logic [SEQ_W-1:0] SQ_ALT  = 4'd2;
  localparam int SQ_TEST_BIT = 3;
  localparam int SQ_INV_BIT  = 2;

  localparam int LD_PC = 0, LD_WD = 1, LD_T1 = 2, LD_T2 = 3;
  localparam int LD_EA = 4, LD_ST = 5, LD_IR = 6, LD_LINK = 7;

  // condition test for codes with the test bit set
  function automatic logic seq_taken(input logic [SEQ_W-1:0] seq,
                                     input logic [FLAG_W-1:0] flags);
    return flags[seq[FSEL_W-1:0]] ^ seq[SQ_INV_BIT];
  endfunction

  function automatic uword_t mk(input logic [UA_W-1:0] a, input logic [UA_W-1:0] nxt,
                                input logic [UA_W-1:0] alt, input logic [UA_W-1:0] ret,
                                input logic [SEQ_W-1:0] seq, input logic [LD_W-1:0] ld);
    uword_t w;
    w       = '0;
    w.nxt   = nxt;
    w.alt   = alt;
    w.ret   = ret;
    w.seq   = seq;
    w.ld    = ld;
    w.konst = {a, ~a};
    return w;
  endfunction

  // control store image; unlisted addresses hold an all-zero word
  function automatic uword_t ucode_image(input logic [UA_W-1:0] a);
    uword_t w;
    case (a)
      8'h00: w = mk(a, 8'h01, 8'h00, 8'h00, SQ_NEXT, 8'h01);
      8'h01: w = mk(a, 8'h08, 8'h00, 8'h02, SQ_NEXT, 8'h80);
      8'h02: w = mk(a, 8'h03, 8'h20, 8'h00, 4'h8,    8'h02);
      8'h03: w = mk(a, 8'h04, 8'h30, 8'h00, 4'hD,    8'h00);
      8'h04: w = mk(a, 8'h04, 8'h00, 8'h00, SQ_NEXT, 8'h00);
      8'h08: begin
        w      = mk(a, 8'h09, 8'h00, 8'h00, SQ_NEXT, 8'h04);
        w.asel = 3'd6;
        w.bsel = 5'd17;
        w.op   = 4'h5;
        w.kdst = 2'd2;
      end
      8'h09: w = mk(a, 8'h55, 8'h00, 8'h00, SQ_RET,  8'h00);
      8'h20: w = mk(a, 8'h04, 8'h00, 8'h00, SQ_NEXT, 8'h08);
      8'h30: w = mk(a, 8'h44, 8'h31, 8'h00, SQ_ALT,  8'h10);
      8'h31: w = mk(a, 8'h04, 8'h00, 8'h00, SQ_NEXT, 8'h20);
      8'h40: w = mk(a, 8'h08, 8'h00, 8'h41, SQ_NEXT, 8'hC0);
      8'h41: w = mk(a, 8'h04, 8'h00, 8'h00, SQ_NEXT, 8'h01);
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
(
  input  logic            clk,
  input  logic [UA_W-1:0] addr,
  output uword_t          q
);
  uword_t img [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_img
    assign img[i] = ucode_image(UA_W'(i));
  end

  // registered read so the store can map to initialised block memory
  always_ff @(posedge clk) q <= img[addr];
endmodule

// File: rtl/ucode_link.sv
module ucode_link
  import ucode_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [UA_W-1:0] din,
  output logic [UA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= din;
  end

  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> q == $past(din)); // R6
endmodule

// File: rtl/useq_next.sv
module useq_next
  import ucode_pkg::*;
(
  input  logic              rst,
  input  logic              disp_vld,
  input  logic [UA_W-1:0]   disp_addr,
  input  logic [FLAG_W-1:0] flags,
  input  logic [SEQ_W-1:0]  seq,
  input  logic [UA_W-1:0]   nxt,
  input  logic [UA_W-1:0]   alt,
  input  logic [UA_W-1:0]   link,
  output logic              br_taken,
  output logic              ret_sel,
  output logic [UA_W-1:0]   rd_addr
);
  logic [UA_W-1:0] seq_addr;

  always_comb begin
    br_taken = 1'b0;
    ret_sel  = 1'b0;
    seq_addr = nxt;
    if (seq[SQ_TEST_BIT]) begin
      br_taken = seq_taken(seq, flags);
      seq_addr = br_taken ? alt : nxt;
    end else if (seq == SQ_RET) begin
      ret_sel  = 1'b1;
      seq_addr = link;
    end else if (seq == SQ_ALT) begin
      br_taken = 1'b1;
      seq_addr = alt;
    end
  end

  assign rd_addr = rst ? '0 : (disp_vld ? disp_addr : seq_addr);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_vld_i,
  input  logic [UA_W-1:0]   disp_addr_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [UA_W-1:0]   upc_o,
  output logic [ASEL_W-1:0] asel_o,
  output logic [BSEL_W-1:0] bsel_o,
  output logic [OP_W-1:0]   aluop_o,
  output logic [K_W-1:0]    konst_o,
  output logic [KD_W-1:0]   kdst_o,
  output logic [LD_W-1:0]   ld_o
);
  uword_t          word;
  logic [UA_W-1:0] rd_addr;
  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] link_q;
  logic            br_taken;
  logic            ret_sel;

  ucode_rom u_rom (.clk(clk), .addr(rd_addr), .q(word));

  ucode_link u_link (
    .clk(clk), .rst(rst), .we(word.ld[LD_LINK]), .din(word.ret), .q(link_q)
  );

  useq_next u_next (
    .rst(rst), .disp_vld(disp_vld_i), .disp_addr(disp_addr_i), .flags(flags_i),
    .seq(word.seq), .nxt(word.nxt), .alt(word.alt), .link(link_q),
    .br_taken(br_taken), .ret_sel(ret_sel), .rd_addr(rd_addr)
  );

  // address register tracks the ROM read so word and upc stay aligned
  always_ff @(posedge clk) upc_q <= rd_addr;

  assign upc_o   = upc_q;
  assign asel_o  = word.asel;
  assign bsel_o  = word.bsel;
  assign aluop_o = word.op;
  assign konst_o = word.konst;
  assign kdst_o  = word.kdst;
  assign ld_o    = word.ld;

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> upc_q == '0); // R1
  AST_DISPATCH_WINS: assert property (@(posedge clk) disable iff (rst)
    disp_vld_i |=> upc_q == $past(disp_addr_i)); // R7
  AST_RETURN_LINK: assert property (@(posedge clk) disable iff (rst)
    (!disp_vld_i && ret_sel) |=> upc_q == $past(link_q)); // R5
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!disp_vld_i && br_taken) |=> upc_q == $past(word.alt)); // R3
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!disp_vld_i && !br_taken && !ret_sel) |=> upc_q == $past(word.nxt)); // R2
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    word.pad == '0); // R9
endmodule

// File: tb/ucode_seq_tb.sv
module ucode_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       disp_vld = 1'b0;
  logic [7:0] disp_addr = '0;
  logic [3:0] flags = '0;
  logic [7:0] upc;
  logic [2:0] asel;
  logic [4:0] bsel;
  logic [3:0] aluop;
  logic [15:0] konst;
  logic [1:0] kdst;
  logic [7:0] ld;

  int n_chk = 0;
  int n_bad = 0;
  logic wd_hit = 1'b0;

  always #4 clk = ~clk;

  ucode_seq u_dut (
    .clk(clk), .rst(rst), .disp_vld_i(disp_vld), .disp_addr_i(disp_addr),
    .flags_i(flags), .upc_o(upc), .asel_o(asel), .bsel_o(bsel), .aluop_o(aluop),
    .konst_o(konst), .kdst_o(kdst), .ld_o(ld)
  );

  // {dispatch, entry, flags, expected upc, expected strobes}
  localparam int NV = 30;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 8'h00, 4'h0, 8'h01, 8'h80},  // R2 successor
    {1'b0, 8'h00, 4'h0, 8'h08, 8'h04},  // R6 call
    {1'b0, 8'h00, 4'h0, 8'h09, 8'h00},
    {1'b0, 8'h00, 4'h0, 8'h02, 8'h02},  // R5 return
    {1'b0, 8'h00, 4'h1, 8'h20, 8'h08},  // R3 taken
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00},
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00},
    {1'b1, 8'h02, 4'h0, 8'h02, 8'h02},  // R7
    {1'b0, 8'h00, 4'h0, 8'h03, 8'h00},  // R3 untaken
    {1'b0, 8'h00, 4'h0, 8'h30, 8'h10},  // R3 inverted taken
    {1'b0, 8'h00, 4'h0, 8'h31, 8'h20},  // R4
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00},
    {1'b1, 8'h03, 4'h0, 8'h03, 8'h00},
    {1'b0, 8'h00, 4'h2, 8'h04, 8'h00},  // R3 inverted untaken
    {1'b1, 8'h40, 4'h0, 8'h40, 8'hC0},
    {1'b0, 8'h00, 4'h0, 8'h08, 8'h04},
    {1'b0, 8'h00, 4'h0, 8'h09, 8'h00},
    {1'b0, 8'h00, 4'h0, 8'h41, 8'h01},  // R6 overwritten link
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00},
    {1'b1, 8'h01, 4'h0, 8'h01, 8'h80},
    {1'b0, 8'h00, 4'h0, 8'h08, 8'h04},
    {1'b0, 8'h00, 4'h0, 8'h09, 8'h00},
    {1'b1, 8'h30, 4'h0, 8'h30, 8'h10},  // R7 over return
    {1'b0, 8'h00, 4'h0, 8'h31, 8'h20},
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00},
    {1'b1, 8'h02, 4'h0, 8'h02, 8'h02},
    {1'b0, 8'h00, 4'hE, 8'h03, 8'h00},  // R3 noise flags, untaken
    {1'b0, 8'h00, 4'hD, 8'h30, 8'h10},  // R3 noise flags, taken
    {1'b0, 8'h00, 4'h0, 8'h31, 8'h20},
    {1'b0, 8'h00, 4'h0, 8'h04, 8'h00}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [7:0] ea, input logic [7:0] el);
    chk(upc == ea, {req, " upc"}, upc, ea);
    chk(konst == {ea, ~ea}, "R8 constant", konst, {ea, ~ea});
    chk(ld == el, "R8 strobes", ld, el);
  endtask

  task automatic step(input logic dv, input logic [7:0] da, input logic [3:0] fl);
    disp_vld  = dv;
    disp_addr = da;
    flags     = fl;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk_word("R1 reset", 8'h00, 8'h01);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
          step(VEC[i][28], VEC[i][27:20], VEC[i][19:16]);
          chk_word($sformatf("R2/R3/R4/R5/R6/R7 vec%0d", i), VEC[i][15:8], VEC[i][7:0]);
        end
        // field decode at the subroutine word
        step(1'b1, 8'h08, 4'h0);
        chk(asel == 3'd6, "R8 asel", asel, 6);
        chk(bsel == 5'd17, "R8 bsel", bsel, 17);
        chk(aluop == 4'h5, "R8 aluop", aluop, 5);
        chk(kdst == 2'd2, "R8 kdst", kdst, 2);
        chk(konst == 16'h08F7, "R9 constant field", konst, 16'h08F7);
        // mid-run reset
        disp_vld = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk_word("R1 mid reset", 8'h00, 8'h01);
        rst = 1'b0;
        step(1'b0, 8'h00, 4'h0);
        chk_word("R1 after reset", 8'h01, 8'h80);
        step(1'b0, 8'h00, 4'h0);
        step(1'b0, 8'h00, 4'h0);
        chk(upc == 8'h09, "R5 at return word", upc, 9);
        step(1'b0, 8'h00, 4'h0);
        chk(upc == 8'h02, "R6 link reloaded after reset", upc, 2);
      end
      begin
        repeat (5000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    if (wd_hit) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule